// File: doc/BRIEF.md
# Loop Cache Controller

This block sits in a processor fetch path and runs short instruction blocks as hardware loops. A **do** command gives an iteration count and a block length of 1 to 15 words. On the first pass the block streams straight from program memory to the decoder, and each word is captured in a small on-chip buffer. Every later pass replays the words from the buffer, with no program-memory traffic.

A **redo** command runs the block already held in the buffer again, for a new number of passes, without reloading it. The count can be given in the command itself. A zero count field takes the count from a 7-bit register that software writes. That register is cleared when a loop that used it completes, so software must write it again before each such command.

Only the timing of each pass is modelled. An instruction occupies its output cycle. A timing exception adds one stall cycle, during which no instruction is presented. The instructions are not decoded here.

Top module: `loopcache_ctl`

## Requirements
- R1: After reset the block is idle: `busy` = 0, `cmd_ready` = 1, `ins_valid` = 0, `ins_stall` = 0, `fetch_req` = 0, both error flags = 0 and `cnt_q` = 0.
- R2: During the first pass of a do, each cycle asserts `fetch_req` and `ins_valid` together, presents `fetch_data` on `ins_data` in that same cycle, and stores the word in the buffer. The buffer position is the word's index in the block.
- R3: On every pass after the first, the buffered words are presented in index order, one per cycle, with `fetch_req` held at 0.
- R4: A non-zero count field K (1 to 127) runs exactly K passes. A block-length field NI of 1 to 15 gives the block length, and NI = 0 is taken as 1.
- R5: A count field of 0 takes the pass count from `cnt_q` as it stands when the command is accepted. A register value of 0 gives a single pass.
- R6: `cnt_we` loads `cnt_wdata` into the count register. When a loop that took its count from the register completes, the register reads 0. A loop with a non-zero count field leaves the register unchanged.
- R7: After the final word of a do's first pass, and after the final word of the last pass, there is exactly one cycle with `ins_stall` = 1 and `ins_valid` = 0. When K = 1 these two stalls coincide in a single stall cycle. No other pass ends in a stall.
- R8: The first word of a do appears in the cycle right after the command is accepted. A redo spends one busy cycle with no output, and its first word appears in the cycle after that.
- R9: A redo replays the word block of the most recent do, using that do's block length. It makes no program-memory fetches, and the NI field of the redo is ignored.
- R10: A redo accepted while the buffer holds no completed block starts nothing: `busy` stays 0. `err_redo` pulses for one cycle, in the cycle after acceptance.
- R11: If `fetch_bad` is high in a first-pass fetch cycle, `err_tag` is 1 in the following cycle and 0 otherwise. `fetch_bad` has no effect in any other cycle.
- R12: `busy` is 1 from the cycle after a do or redo is accepted until the last stall cycle ends. `cmd_ready` is the inverse of `busy`, and a command held while busy is accepted once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_redo | input | 1 | 0 = do, 1 = redo |
| cmd_k | input | 7 | Pass count; 0 selects the count register |
| cmd_ni | input | 4 | Block length in words (do only) |
| cnt_we | input | 1 | Count register write enable |
| cnt_wdata | input | 7 | Count register write value |
| cnt_q | output | 7 | Count register contents |
| fetch_req | output | 1 | Program-memory word consumed this cycle |
| fetch_data | input | DW | Program-memory word, valid in the same cycle as `fetch_req` |
| fetch_bad | input | 1 | Fetched word is a control-flow or long-immediate word |
| ins_valid | output | 1 | Instruction word presented to the decoder |
| ins_data | output | DW | Instruction word |
| ins_stall | output | 1 | Timing-exception stall cycle |
| busy | output | 1 | Loop in progress |
| err_redo | output | 1 | Pulse: redo issued with an empty buffer |
| err_tag | output | 1 | Pulse: disallowed word fetched into the buffer |

## Verification
The checker relies on program memory returning its word in the same cycle that `fetch_req` is high. It also relies on `fetch_bad` being judged only in fill cycles. The bench meets this by deriving both `fetch_data` and the bad-word tag combinationally from a fetch counter, which advances only on cycles with `fetch_req` high. The checker further relies on commands being sampled only while `cmd_ready` is high, so a command held during a loop is expected to wait. The bench drives every input on the falling edge, and never changes the count register in the same cycle as a command it is checking.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int CNT_W = 7;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RWAIT,
    ST_PLAY,
    ST_STALL
  } lc_state_e;

  // Number of passes a command runs: an immediate field wins, otherwise the
  // register; an empty register still yields one pass.
  function automatic cnt_t pass_total(input cnt_t k_field, input cnt_t reg_val);
    if (k_field != '0) return k_field;
    if (reg_val != '0) return reg_val;
    return cnt_t'(1);
  endfunction

  // A pass ends with an extra stall cycle when it is the fetch pass or the last.
  function automatic logic stall_due(input logic first_pass, input logic last_pass);
    return first_pass | last_pass;
  endfunction
endpackage

// File: rtl/lc_count_reg.sv
module lc_count_reg
  import lc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cnt_t wr_data,
  input  logic clr,
  input  cnt_t k_field,
  output cnt_t count_q,
  output cnt_t passes,
  output logic reg_sel
);
  cnt_t cnt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_r <= '0;
    else if (clr)   cnt_r <= '0;
    else if (wr_en) cnt_r <= wr_data;
  end

  assign count_q = cnt_r;
  assign passes  = pass_total(k_field, cnt_r);
  assign reg_sel = (k_field == '0);
endmodule

// File: rtl/lc_block_store.sv
module lc_block_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 15,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (wr_en && (wr_idx == AW'(e))) mem[e] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/lc_seq.sv
module lc_seq
  import lc_pkg::*;
#(
  parameter int NIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_fire,
  input  logic           cmd_redo,
  input  logic [NIW-1:0] ni_field,
  input  cnt_t           passes_in,
  input  logic           reg_sel,
  input  logic           fetch_bad,
  output logic           fill_active,
  output logic           play_active,
  output logic           stall_active,
  output logic           busy,
  output logic [NIW-1:0] idx,
  output logic           pass_end,
  output logic           loop_done,
  output logic           reg_src,
  output logic           buf_full,
  output logic           err_redo,
  output logic           err_tag
);
  lc_state_e      st;
  logic [NIW-1:0] idx_r, ni_r, held_ni;
  cnt_t           left;
  logic           first_r, fin_r, reg_src_r, full_r, e_redo, e_tag;
  logic [NIW-1:0] ni_eff;
  logic           last_pass, stall_now;

  assign ni_eff       = (ni_field == '0) ? NIW'(1) : ni_field;
  assign fill_active  = (st == ST_FILL);
  assign play_active  = (st == ST_PLAY);
  assign stall_active = (st == ST_STALL);
  assign busy         = (st != ST_IDLE);
  assign pass_end     = (fill_active || play_active) && (idx_r == NIW'(ni_r - NIW'(1)));
  assign last_pass    = (left == cnt_t'(1));
  assign stall_now    = stall_due(first_r, last_pass);
  assign loop_done    = stall_active && fin_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx_r     <= '0;
      ni_r      <= NIW'(1);
      held_ni   <= NIW'(1);
      left      <= '0;
      first_r   <= 1'b0;
      fin_r     <= 1'b0;
      reg_src_r <= 1'b0;
      full_r    <= 1'b0;
      e_redo    <= 1'b0;
      e_tag     <= 1'b0;
    end else begin
      e_redo <= 1'b0;
      e_tag  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cmd_fire) begin
            if (!cmd_redo) begin
              st        <= ST_FILL;
              idx_r     <= '0;
              ni_r      <= ni_eff;
              left      <= passes_in;
              first_r   <= 1'b1;
              reg_src_r <= reg_sel;
              full_r    <= 1'b0;
            end else if (full_r) begin
              st        <= ST_RWAIT;
              idx_r     <= '0;
              ni_r      <= held_ni;
              left      <= passes_in;
              first_r   <= 1'b0;
              reg_src_r <= reg_sel;
            end else begin
              e_redo <= 1'b1;
            end
          end
        end
        ST_FILL, ST_PLAY: begin
          if (st == ST_FILL) begin
            e_tag <= fetch_bad;
            if (pass_end) begin
              full_r  <= 1'b1;
              held_ni <= ni_r;
            end
          end
          if (pass_end) begin
            first_r <= 1'b0;
            left    <= left - cnt_t'(1);
            idx_r   <= '0;
            fin_r   <= last_pass;
            st      <= stall_now ? ST_STALL : ST_PLAY;
          end else begin
            idx_r <= idx_r + NIW'(1);
          end
        end
        ST_RWAIT: st <= ST_PLAY;
        ST_STALL: st <= fin_r ? ST_IDLE : ST_PLAY;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign idx      = idx_r;
  assign reg_src  = reg_src_r;
  assign buf_full = full_r;
  assign err_redo = e_redo;
  assign err_tag  = e_tag;
endmodule

// File: rtl/loopcache_ctl.sv
module loopcache_ctl
  import lc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_redo,
  input  logic [CNT_W-1:0]            cmd_k,
  input  logic [$clog2(DEPTH+1)-1:0]  cmd_ni,
  input  logic                        cnt_we,
  input  logic [CNT_W-1:0]            cnt_wdata,
  output logic [CNT_W-1:0]            cnt_q,
  output logic                        fetch_req,
  input  logic [DW-1:0]               fetch_data,
  input  logic                        fetch_bad,
  output logic                        ins_valid,
  output logic [DW-1:0]               ins_data,
  output logic                        ins_stall,
  output logic                        busy,
  output logic                        err_redo,
  output logic                        err_tag
);
  localparam int NIW = $clog2(DEPTH + 1);

  logic           cmd_fire, fill_active, play_active, stall_active;
  logic           pass_end, loop_done, reg_src, buf_full, reg_sel;
  logic [NIW-1:0] idx;
  logic [DW-1:0]  rd_data;
  cnt_t           passes;

  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;

  lc_count_reg u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_we),
    .wr_data (cnt_wdata),
    .clr     (loop_done && reg_src),
    .k_field (cmd_k),
    .count_q (cnt_q),
    .passes  (passes),
    .reg_sel (reg_sel)
  );

  lc_seq #(.NIW(NIW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_fire     (cmd_fire),
    .cmd_redo     (cmd_redo),
    .ni_field     (cmd_ni),
    .passes_in    (passes),
    .reg_sel      (reg_sel),
    .fetch_bad    (fetch_bad),
    .fill_active  (fill_active),
    .play_active  (play_active),
    .stall_active (stall_active),
    .busy         (busy),
    .idx          (idx),
    .pass_end     (pass_end),
    .loop_done    (loop_done),
    .reg_src      (reg_src),
    .buf_full     (buf_full),
    .err_redo     (err_redo),
    .err_tag      (err_tag)
  );

  lc_block_store #(.DW(DW), .DEPTH(DEPTH), .AW(NIW)) u_store (
    .clk     (clk),
    .wr_en   (fill_active),
    .wr_idx  (idx),
    .wr_data (fetch_data),
    .rd_idx  (idx),
    .rd_data (rd_data)
  );

  assign fetch_req = fill_active;
  assign ins_valid = fill_active || play_active;
  assign ins_data  = fill_active ? fetch_data : rd_data;
  assign ins_stall = stall_active;
endmodule

// File: rtl/lc_chk.sv
module lc_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_redo,
  input logic          fetch_req,
  input logic          fetch_bad,
  input logic [DW-1:0] fetch_data,
  input logic          ins_valid,
  input logic [DW-1:0] ins_data,
  input logic          ins_stall,
  input logic          busy,
  input logic          err_redo,
  input logic          err_tag,
  input logic [6:0]    cnt_q,
  input logic          buf_full,
  input logic          loop_done,
  input logic          reg_src
);
  // R2
  fill_pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (ins_valid && ins_data == fetch_data));

  // R7
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_stall |-> (!ins_valid && busy) ##1 !ins_stall);

  // R8
  do_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_redo) |=> (fetch_req && ins_valid));

  // R8
  redo_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_redo && buf_full) |=> (busy && !ins_valid) ##1 (ins_valid && !fetch_req));

  // R10
  redo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_redo && !buf_full) |=> (err_redo && !busy));

  // R11
  tag_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_bad) |=> err_tag);

  // R6
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_done && reg_src) |=> (cnt_q == 7'd0 && !busy));

  // R12
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !cmd_ready);
endmodule

bind loopcache_ctl lc_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_redo   (cmd_redo),
  .fetch_req  (fetch_req),
  .fetch_bad  (fetch_bad),
  .fetch_data (fetch_data),
  .ins_valid  (ins_valid),
  .ins_data   (ins_data),
  .ins_stall  (ins_stall),
  .busy       (busy),
  .err_redo   (err_redo),
  .err_tag    (err_tag),
  .cnt_q      (cnt_q),
  .buf_full   (buf_full),
  .loop_done  (loop_done),
  .reg_src    (reg_src)
);

// File: tb/sim_loopcache_ctl.sv
module sim_loopcache_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {redo, K field, NI field, count register value}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 7'd1,   4'd3,  7'd9},
    {1'b0, 7'd2,   4'd3,  7'd9},
    {1'b0, 7'd4,   4'd1,  7'd0},
    {1'b0, 7'd3,   4'd15, 7'd0},
    {1'b1, 7'd2,   4'd0,  7'd44},
    {1'b0, 7'd0,   4'd2,  7'd5},
    {1'b1, 7'd0,   4'd9,  7'd3},
    {1'b0, 7'd0,   4'd0,  7'd0},
    {1'b1, 7'd127, 4'd0,  7'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_redo = 1'b0, cnt_we = 1'b0;
  logic [6:0] cmd_k = '0, cnt_wdata = '0;
  logic [3:0] cmd_ni = '0;
  logic cmd_ready, fetch_req, ins_valid, ins_stall, busy, err_redo, err_tag, fetch_bad;
  logic [6:0] cnt_q;
  logic [15:0] fetch_data, ins_data;
  logic [15:0] fcnt = '0;
  logic bad_en = 1'b0;
  logic [15:0] bad_word = '0;
  int checks = 0, fails = 0;
  logic [15:0] last_base = '0;
  int last_ni = 1;
  logic prev_bad;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (fetch_req) fcnt <= fcnt + 16'd1;
  assign fetch_data = 16'hC000 + fcnt;
  assign fetch_bad  = bad_en && (fcnt == bad_word);

  loopcache_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_redo(cmd_redo), .cmd_k(cmd_k), .cmd_ni(cmd_ni), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .fetch_req(fetch_req),
    .fetch_data(fetch_data), .fetch_bad(fetch_bad), .ins_valid(ins_valid),
    .ins_data(ins_data), .ins_stall(ins_stall), .busy(busy),
    .err_redo(err_redo), .err_tag(err_tag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp_v, $time);
    end
  endtask

  // One busy cycle, sampled at the falling edge, then advance.
  task automatic exp_cycle(input string req, input logic v, input logic st,
                           input logic fr, input logic [15:0] d);
    check({req, " R12 busy/ready"}, {30'd0, busy, cmd_ready}, 32'd2);
    check({req, " valid/stall/fetch"}, {29'd0, ins_valid, ins_stall, fetch_req}, {29'd0, v, st, fr});
    if (v) check({req, " data"}, {16'd0, ins_data}, {16'd0, d});
    check("R11 err_tag", {31'd0, err_tag}, {31'd0, prev_bad});
    prev_bad = fr && bad_en && (d == 16'hC000 + bad_word);
    @(negedge clk);
  endtask

  task automatic write_cnt(input logic [6:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // Issue a command and follow it cycle by cycle against the model.
  task automatic run_cmd(input logic redo, input logic [6:0] k, input logic [3:0] ni);
    int eff, n;
    logic [15:0] base;
    logic [6:0] cnt_before;
    cnt_before = cnt_q;
    eff = (k != 0) ? int'(k) : ((cnt_before != 0) ? int'(cnt_before) : 1);
    n = redo ? last_ni : ((ni == 0) ? 1 : int'(ni));
    base = redo ? last_base : (16'hC000 + fcnt);
    prev_bad = 1'b0;
    check("R12 ready before command", {31'd0, cmd_ready}, 32'd1);
    cmd_valid = 1'b1; cmd_redo = redo; cmd_k = k; cmd_ni = ni;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (redo) exp_cycle("R8 redo wait", 1'b0, 1'b0, 1'b0, 16'd0);
    for (int p = 1; p <= eff; p++) begin
      for (int j = 0; j < n; j++) begin
        if (!redo && p == 1) exp_cycle("R2 fill", 1'b1, 1'b0, 1'b1, base + 16'(j));
        else exp_cycle(redo ? "R9 replay" : "R3 replay", 1'b1, 1'b0, 1'b0, base + 16'(j));
      end
      if ((p == 1 && !redo) || p == eff) exp_cycle("R7 stall", 1'b0, 1'b1, 1'b0, 16'd0);
    end
    check("R4 idle after passes", {30'd0, busy, cmd_ready}, 32'd1);
    check("R11 err_tag end", {31'd0, err_tag}, {31'd0, prev_bad});
    if (k == 0) check("R5 R6 count register cleared", {25'd0, cnt_q}, 32'd0);
    else check("R6 count register kept", {25'd0, cnt_q}, {25'd0, cnt_before});
    if (!redo) begin last_base = base; last_ni = n; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 ready", {31'd0, cmd_ready}, 32'd1);
    check("R1 outputs", {27'd0, ins_valid, ins_stall, fetch_req, err_redo, err_tag}, 32'd0);
    check("R1 count", {25'd0, cnt_q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 redo with nothing buffered
    cmd_valid = 1'b1; cmd_redo = 1'b1; cmd_k = 7'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 err_redo pulse", {31'd0, err_redo}, 32'd1);
    check("R10 not busy", {30'd0, busy, ins_valid}, 32'd0);
    @(negedge clk);
    check("R10 pulse ends", {31'd0, err_redo}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      write_cnt(VEC[i][6:0]);
      check("R6 count write", {25'd0, cnt_q}, {25'd0, VEC[i][6:0]});
      run_cmd(VEC[i][18], VEC[i][17:11], VEC[i][10:7]);
      @(negedge clk);
    end

    // R11 tagged word in fill, and the same word on replay raises nothing
    bad_en = 1'b1; bad_word = fcnt + 16'd1;
    run_cmd(1'b0, 7'd2, 4'd2);
    bad_en = 1'b0;

    // R12 a command held during a loop waits for busy to fall
    cmd_valid = 1'b1; cmd_redo = 1'b0; cmd_k = 7'd1; cmd_ni = 4'd1;
    @(negedge clk);
    cmd_redo = 1'b1;
    check("R12 held off", {30'd0, cmd_ready, ins_valid}, 32'd1);
    @(negedge clk);
    check("R12 stall still busy", {30'd0, cmd_ready, ins_stall}, 32'd1);
    @(negedge clk);
    check("R12 ready again", {31'd0, cmd_ready}, 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R12 held redo accepted", {30'd0, busy, ins_valid}, 32'd2);
    @(negedge clk);
    check("R9 held redo word", {15'd0, ins_valid, ins_data}, {15'd0, 1'b1, fcnt - 16'd1 + 16'hC000});
    check("R9 no fetch", {31'd0, fetch_req}, 32'd0);
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule